// File: doc/BRIEF.md
# Acquisition Cycle and Busy Controller

This block steps a group of front-end readout chips through a repeating three-phase cycle. First comes acquisition, where charge is stored. Next comes conversion, where the stored samples are digitised. Last comes readout, where the data is shifted out. Each phase has one power-enable output, so the preamplifiers, the converter and the digital readout logic draw power only while their phase is active.

A start command opens the acquisition window. The window can be accepted only when the downstream aggregator reports room for a full cycle. Whichever of these comes first closes the window:
- a stop command,
- a programmable cycle-count limit,
- a memory-full flag from any chip.

The same limit serves both uses. It can be set short for collider-style running, about 1 ms. It can be set long for beam-test running, up to about 16 ms.

A memory-full flag raises a busy output to the upstream aggregator. Busy stays high until readout reports that the data has drained. The conversion and readout phases are each guarded by a watchdog, which aborts the cycle to idle and sets an error flag. A start command that arrives while a cycle is in progress is discarded and counted.

Top module: `acq_cycle_ctrl`

## Requirements
- R1: At most one power enable is high at any time, and none is high in idle. The preamplifier enable is high only in acquisition, the converter enable only in conversion, and the readout enable only in readout.
- R2: In idle, a start with space available moves the block to acquisition at the next clock edge. A start without space available leaves the block in idle.
- R3: With no stop and no full flag, acquisition lasts exactly `win_limit_i` cycles, for `win_limit_i` of 1 or more.
- R4: A stop sampled during acquisition ends it at that edge, and conversion follows.
- R5: Any memory-full flag sampled during acquisition ends acquisition at that edge and raises busy.
- R6: Busy stays high through conversion and readout, and it drops when readout completes. A full flag seen in idle does not raise busy.
- R7: Conversion ends on `conv_done_i`, and readout follows. Readout ends on `ro_done_i`, and idle follows.
- R8: If conversion or readout lasts `WDOG_CYC` cycles without its done input, the block returns to idle and `err_o` is set. The next accepted start clears `err_o`.
- R9: Each cycle in which start is high outside idle adds one to `ign_start_cnt_o`. The count saturates at its maximum value, and the cycle in progress is not disturbed.
- R10: `phase_o` gives the state: 0 for idle, 1 for acquisition, 2 for conversion, 3 for readout.
- R11: After reset the block is idle, and every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command |
| stop_i | input | 1 | Stop command |
| win_limit_i | input | WIN_W | Acquisition window length in cycles |
| asic_full_i | input | N_ASIC | Memory-full flag, one per chip |
| conv_done_i | input | 1 | Conversion finished |
| ro_done_i | input | 1 | All data sent out |
| space_ok_i | input | 1 | Downstream has room for a cycle |
| pwr_preamp_o | output | 1 | Preamplifier power enable |
| pwr_adc_o | output | 1 | Converter power enable |
| pwr_dig_o | output | 1 | Readout logic power enable |
| busy_o | output | 1 | Busy to upstream aggregator |
| phase_o | output | 2 | Current phase code |
| err_o | output | 1 | Watchdog abort flag |
| ign_start_cnt_o | output | CNT_W | Count of discarded starts |

## Verification
The main loop runs complete cycles in which the window closes in different ways:
- by reaching the count limit, including the minimum limit of one cycle,
- by an early stop,
- by a full flag on different chips, including a full flag on the last cycle of the window,
- by stop and full arriving together.

Measuring the length of acquisition and the state of busy separates a timeout from a stop from a full-driven close, since only the full-driven close raises busy. Directed runs cover the remaining cases:
- a start with no downstream space,
- a full flag in idle,
- starts during acquisition, up to saturation of the counter,
- a stalled conversion, which shows the watchdog abort and the clearing of the error flag.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2,
    ST_RO   = 2'd3
  } acq_state_e;
endpackage

// File: rtl/acq_phase_timer.sv
module acq_phase_timer #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   cnt_p1;

  assign cnt_p1   = {1'b0, cnt_q} + 1'b1;
  assign expire_o = cnt_p1 >= {1'b0, limit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (!(&cnt_q)) cnt_q <= cnt_q + 1'b1;
  end

  a_r3_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(&cnt_q)) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/acq_busy_ctrl.sv
module acq_busy_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic busy_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_q <= 1'b0;
    else if (clr_i)  busy_q <= 1'b0;
    else if (set_i)  busy_q <= 1'b1;
  end

  assign busy_o = busy_q;

  a_r6_busy_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !clr_i) |=> busy_q);
endmodule

// File: rtl/acq_start_mon.sv
module acq_start_mon #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             idle_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (start_i && !idle_i && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r9_cnt_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q >= $past(cnt_q)));
  a_r9_idle_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |=> $stable(cnt_q));
endmodule

// File: rtl/acq_cycle_ctrl.sv
module acq_cycle_ctrl
  import acq_pkg::*;
#(
  parameter int N_ASIC   = 4,
  parameter int WIN_W    = 24,
  parameter int WDOG_CYC = 65536,
  parameter int CNT_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [WIN_W-1:0]  win_limit_i,
  input  logic [N_ASIC-1:0] asic_full_i,
  input  logic              conv_done_i,
  input  logic              ro_done_i,
  input  logic              space_ok_i,
  output logic              pwr_preamp_o,
  output logic              pwr_adc_o,
  output logic              pwr_dig_o,
  output logic              busy_o,
  output logic [1:0]        phase_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  ign_start_cnt_o
);
  localparam int WD_W  = $clog2(WDOG_CYC + 1);
  localparam int TMR_W = (WIN_W > WD_W) ? WIN_W : WD_W;

  acq_state_e state_q, state_d;
  logic       full_any, tmr_exp, wd_abort, accept, err_q;
  logic [TMR_W-1:0] tmr_limit;

  assign full_any = |asic_full_i;
  assign accept   = (state_q == ST_IDLE) && (state_d == ST_ACQ);

  always_comb begin
    state_d  = state_q;
    wd_abort = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i && space_ok_i) state_d = ST_ACQ;
      ST_ACQ:  if (stop_i || full_any || tmr_exp) state_d = ST_CONV;
      ST_CONV: begin
        if (conv_done_i) state_d = ST_RO;
        else if (tmr_exp) begin
          state_d  = ST_IDLE;
          wd_abort = 1'b1;
        end
      end
      ST_RO: begin
        if (ro_done_i) state_d = ST_IDLE;
        else if (tmr_exp) begin
          state_d  = ST_IDLE;
          wd_abort = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (wd_abort)    err_q <= 1'b1;
      else if (accept) err_q <= 1'b0;
    end
  end

  assign tmr_limit = (state_q == ST_ACQ) ? TMR_W'(win_limit_i) : TMR_W'(WDOG_CYC);

  acq_phase_timer #(.W(TMR_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_d != state_q),
    .limit_i  (tmr_limit),
    .expire_o (tmr_exp)
  );

  acq_busy_ctrl u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ((state_q == ST_ACQ) && full_any),
    .clr_i  ((state_q != ST_IDLE) && (state_d == ST_IDLE)),
    .busy_o (busy_o)
  );

  acq_start_mon #(.CNT_W(CNT_W)) u_start_mon (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .idle_i  (state_q == ST_IDLE),
    .cnt_o   (ign_start_cnt_o)
  );

  assign pwr_preamp_o = (state_q == ST_ACQ);
  assign pwr_adc_o    = (state_q == ST_CONV);
  assign pwr_dig_o    = (state_q == ST_RO);
  assign phase_o      = state_q;
  assign err_o        = err_q;

  a_r1_pwr_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pwr_preamp_o, pwr_adc_o, pwr_dig_o}));
  a_r2_no_space_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !space_ok_i) |=> (state_q == ST_IDLE));
  a_r4_stop_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACQ && stop_i) |=> (state_q == ST_CONV));
  a_r5_full_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACQ && full_any) |=> (busy_o && state_q == ST_CONV));
  a_r6_idle_full_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !busy_o) |=> !busy_o);
  a_r7_acq_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACQ) |=> (state_q == ST_ACQ || state_q == ST_CONV));
  a_r8_abort_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_abort |=> (err_o && state_q == ST_IDLE));
endmodule

// File: tb/sim_acq_cycle_ctrl.sv
module sim_acq_cycle_ctrl;
  localparam int N_ASIC = 4, WIN_W = 16, WDOG = 20, CNT_W = 4;

  logic clk = 0, rst_ni = 0;
  logic start_i = 0, stop_i = 0, conv_done_i = 0, ro_done_i = 0, space_ok_i = 0;
  logic [WIN_W-1:0]  win_limit_i = '0;
  logic [N_ASIC-1:0] asic_full_i = '0;
  logic pwr_preamp_o, pwr_adc_o, pwr_dig_o, busy_o, err_o;
  logic [1:0] phase_o;
  logic [CNT_W-1:0] ign_start_cnt_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  acq_cycle_ctrl #(.N_ASIC(N_ASIC), .WIN_W(WIN_W), .WDOG_CYC(WDOG), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .win_limit_i(win_limit_i), .asic_full_i(asic_full_i), .conv_done_i(conv_done_i),
    .ro_done_i(ro_done_i), .space_ok_i(space_ok_i), .pwr_preamp_o(pwr_preamp_o),
    .pwr_adc_o(pwr_adc_o), .pwr_dig_o(pwr_dig_o), .busy_o(busy_o), .phase_o(phase_o),
    .err_o(err_o), .ign_start_cnt_o(ign_start_cnt_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // limit, stop_at, full_at, full_idx, exp_len, exp_busy
  localparam int NV = 7;
  localparam int VEC [NV][6] = '{
    '{10, 0, 0, 0, 10, 0},
    '{10, 4, 0, 0,  4, 0},
    '{10, 0, 3, 2,  3, 1},
    '{ 1, 0, 0, 0,  1, 0},
    '{10, 5, 5, 1,  5, 1},
    '{ 8, 0, 8, 3,  8, 1},
    '{40, 7, 0, 0,  7, 0}
  };

  task automatic open_acq(input int lim);
    @(negedge clk);
    win_limit_i = WIN_W'(lim); space_ok_i = 1; start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
    chk(pwr_adc_o && phase_o == 2, "R1 R10 conv phase", phase_o, 2);
    conv_done_i = 1; @(negedge clk); conv_done_i = 0;
    chk(pwr_dig_o && !pwr_adc_o && phase_o == 3, "R7 readout after conv", phase_o, 3);
    repeat (2) @(negedge clk);
    ro_done_i = 1; @(negedge clk); ro_done_i = 0;
    asic_full_i = '0;
    chk(phase_o == 0 && !pwr_dig_o, "R7 idle after readout", phase_o, 0);
    chk(!busy_o, "R6 busy cleared", busy_o, 0);
  endtask

  initial begin
    int len;
    repeat (3) @(negedge clk);
    chk({pwr_preamp_o, pwr_adc_o, pwr_dig_o, busy_o, err_o} == 0 && phase_o == 0
        && ign_start_cnt_o == 0, "R11 reset state", phase_o, 0);
    rst_ni = 1;

    for (int v = 0; v < NV; v++) begin
      open_acq(VEC[v][0]);
      chk(phase_o == 1, "R2 start accepted", phase_o, 1);
      len = 0;
      while (pwr_preamp_o && len < 300) begin
        len++;
        if (len == VEC[v][1]) stop_i = 1;
        if (len == VEC[v][2]) asic_full_i[VEC[v][3]] = 1;
        @(negedge clk);
        stop_i = 0;
      end
      chk(len == VEC[v][4], "R3 R4 R5 acq length", len, VEC[v][4]);
      chk(busy_o == VEC[v][5][0], "R5 busy after acq", busy_o, VEC[v][5]);
      chk(pwr_adc_o, "R1 conv power", pwr_adc_o, 1);
      if (VEC[v][5] != 0) begin
        @(negedge clk);
        chk(busy_o, "R6 busy held in conv", busy_o, 1);
      end
      drain();
    end

    // R2: no space keeps idle
    @(negedge clk); space_ok_i = 0; start_i = 1;
    repeat (3) @(negedge clk);
    start_i = 0;
    chk(phase_o == 0 && !pwr_preamp_o, "R2 no space stays idle", phase_o, 0);
    chk(ign_start_cnt_o == 0, "R9 idle starts not counted", ign_start_cnt_o, 0);

    // R6: full in idle ignored
    asic_full_i = 4'b0001; repeat (3) @(negedge clk);
    chk(!busy_o && phase_o == 0, "R6 full in idle no busy", busy_o, 0);
    asic_full_i = '0;

    // R9: starts during acquisition
    open_acq(10);
    len = 0;
    while (pwr_preamp_o && len < 300) begin
      len++;
      if (len == 2 || len == 4) start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    chk(len == 10, "R9 acq undisturbed", len, 10);
    chk(ign_start_cnt_o == 2, "R9 ignored starts counted", ign_start_cnt_o, 2);
    drain();

    open_acq(100);
    start_i = 1; repeat (30) @(negedge clk); start_i = 0;
    chk(ign_start_cnt_o == 15, "R9 counter saturates", ign_start_cnt_o, 15);
    stop_i = 1; @(negedge clk); stop_i = 0;
    drain();

    // R8: conversion watchdog
    open_acq(3);
    while (pwr_preamp_o) @(negedge clk);
    len = 0;
    while (pwr_adc_o && len < 300) begin len++; @(negedge clk); end
    chk(len == WDOG, "R8 watchdog length", len, WDOG);
    chk(err_o && phase_o == 0, "R8 abort to idle with err", err_o, 1);
    open_acq(5);
    chk(!err_o && phase_o == 1, "R8 err cleared on start", err_o, 0);
    while (pwr_preamp_o) @(negedge clk);
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule